// File: doc/BRIEF.md
# Secured Flash Access Controller

This block stands between an external programming or serial access port and an on-chip flash array, which is modelled here as a byte-wide register array. Each request on a single-beat request port is one of four operations: read, byte program, page erase or whole-array erase. The block accepts or rejects the request under a security policy. That policy is controlled by a one-byte configuration word held at the highest flash address.

A configuration word with its security bit set hides program contents from the port: every read returns 0xFF and every program or page erase is refused. The configuration word itself stays readable, both at its physical location and at the fixed alias address 0xFFFF. A whole-array erase is always honoured. Because the erased state is 0x00, that erase also clears the security bit. The configuration word is programmed once. It can be programmed again only after the page that holds it has been erased.

The boot-source bit and the halt-disable bit of the configuration word are captured into output registers while reset is held. These outputs drive the rest of the chip and keep their value until the next reset.

Top module: `secflash_ctrl`

## Requirements
- R1: A read (op code 2'b00) of an in-range address returns the stored byte on `rdata` with `err`=0. Every byte of a fresh or erased array reads 0x00.
- R2: A program request (op code 2'b01) ORs the write data into the stored byte, so bits can only be set. The request is rejected (`err`=1) while the device is secured.
- R3: While secured, a read of any program address returns 0xFF with `err`=0. The configuration byte is the exception and reads its true value at the top physical address.
- R4: A page erase (op code 2'b10) clears to 0x00 every byte of the 128-byte page that holds the request address. While secured it is rejected at once, and `busy` is never raised.
- R5: A whole-array erase (op code 2'b11) is accepted whether or not the device is secured. It clears every byte, the configuration byte included.
- R6: After one program of the configuration byte, further programs of it are rejected. The lock holds across reset and is released by erasing the last page or the whole array.
- R7: A read at address 0xFFFF returns the configuration byte in any security state. Any other address at or above the array size is rejected with `err`=1.
- R8: `boot_flash` (configuration bit 0, 1 = start from flash) and `halt_dis` (bit 1, 1 = halt disabled) are captured while `rst` is high. They stay unchanged until the next reset.
- R9: Configuration bit 2 is the security bit, and 1 means secured. The bit takes effect as soon as the configuration byte is programmed.
- R10: Every request ends with a one-cycle `done` pulse, and `err` is valid in the same cycle. An accepted erase holds `busy` for ERASE_WAIT cycles plus one cycle per erased byte.
- R11: A request presented while `busy` is high is ignored. It produces no `done` and changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples the configuration outputs |
| req_valid | input | 1 | Request strobe, sampled while `busy` is low |
| req_op | input | 2 | 00 read, 01 program, 10 page erase, 11 whole-array erase |
| req_addr | input | 16 | Byte address; 0xFFFF is the configuration alias |
| req_wdata | input | 8 | Data to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected, valid with `done` |
| rdata | output | 8 | Read result, valid with `done` |
| boot_flash | output | 1 | Captured boot-source bit |
| halt_dis | output | 1 | Captured halt-disable bit |

## Verification
A wrong security state shows up on the next read: the port returns 0xFF where it should return data, or the reverse. It also shows up on the next program or page erase, which completes with the wrong `err` one cycle after the request. A lock flag that is wrong becomes visible only at the second program of the configuration byte, or when that byte is read after a last-page erase. A fault in the erase sequencer shows as a wrong `busy` length and as stray non-zero bytes when the erased range is read back.

// File: rtl/secflash_pkg.sv
package secflash_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_PERASE = 2'b10,
    OP_MERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SEL_MEM  = 2'b00,
    SEL_OPT  = 2'b01,
    SEL_ONES = 2'b10
  } rsel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WR, ST_WAIT, ST_WALK
  } st_e;

  localparam int BOOT_BIT = 0;
  localparam int HALT_BIT = 1;
  localparam int SEC_BIT  = 2;
endpackage

// File: rtl/secflash_policy.sv
module secflash_policy
  import secflash_pkg::*;
#(
  parameter int MEM_AW  = 11,
  parameter int PAGE_AW = 7
) (
  input  op_e         op,
  input  logic [15:0] addr,
  input  logic        secure,
  input  logic        lock,
  output logic        accept,
  output logic        opt_hit,
  output logic        last_page,
  output rsel_e       rsel
);
  logic in_range, alias_hit;

  always_comb begin
    in_range  = (addr[15:MEM_AW] == '0);
    alias_hit = &addr;
    opt_hit   = alias_hit | (in_range & (&addr[MEM_AW-1:0]));
    last_page = in_range & (&addr[MEM_AW-1:PAGE_AW]);
    rsel      = opt_hit ? SEL_OPT : (secure ? SEL_ONES : SEL_MEM);
    unique case (op)
      OP_READ:   accept = in_range | alias_hit;
      OP_WRITE:  accept = (in_range | alias_hit) & ~secure & ~(opt_hit & lock);
      OP_PERASE: accept = in_range & ~secure;
      default:   accept = 1'b1;
    endcase
  end
endmodule

// File: rtl/secflash_array.sv
module secflash_array #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/secflash_optreg.sv
module secflash_optreg
  import secflash_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       clr,
  output logic [7:0] opt_byte,
  output logic       lock,
  output logic       secure,
  output logic       boot_flash,
  output logic       halt_dis
);
  logic [7:0] shadow = 8'h00;
  logic       lock_q = 1'b0;

  // Non-volatile state: survives rst, changed only by program and erase.
  always_ff @(posedge clk) begin
    if (clr) begin
      shadow <= 8'h00;
      lock_q <= 1'b0;
    end else if (wr_en) begin
      shadow <= shadow | wdata;
      lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_flash <= shadow[BOOT_BIT];
      halt_dis   <= shadow[HALT_BIT];
    end
  end

  assign opt_byte = shadow;
  assign lock     = lock_q;
  assign secure   = shadow[SEC_BIT];

  // R6
  opt_write_once_chk: assert property (@(posedge clk) wr_en |-> !lock_q);
  // R8
  cfg_outputs_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($stable(boot_flash) && $stable(halt_dis)));
endmodule

// File: rtl/secflash_ctrl.sv
module secflash_ctrl
  import secflash_pkg::*;
#(
  parameter int MEM_AW     = 11,
  parameter int PAGE_BYTES = 128,
  parameter int ERASE_WAIT = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [7:0]  rdata,
  output logic        boot_flash,
  output logic        halt_dis
);
  localparam int DEPTH   = 1 << MEM_AW;
  localparam int PAGE_AW = $clog2(PAGE_BYTES);
  localparam int WAIT_W  = $clog2(ERASE_WAIT + 1);
  localparam int CNT_W   = ((MEM_AW > WAIT_W) ? MEM_AW : WAIT_W) + 1;

  st_e               state;
  rsel_e             rsel_q, rsel_d;
  logic [MEM_AW-1:0] a_q, ptr;
  logic [7:0]        wd_q;
  logic              optw_q, mass_q;
  logic [CNT_W-1:0]  cnt;

  logic              accept, opt_hit, last_page;
  logic              secure, lock, take;
  logic [7:0]        opt_byte, mem_rdata, mem_wdata;
  logic              mem_we, opt_wr_en, opt_clr;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr;
  op_e               op;

  assign op   = op_e'(req_op);
  assign busy = (state != ST_IDLE);
  assign take = (state == ST_IDLE) && req_valid;

  secflash_policy #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_policy (
    .op(op), .addr(req_addr), .secure(secure), .lock(lock),
    .accept(accept), .opt_hit(opt_hit), .last_page(last_page), .rsel(rsel_d)
  );

  assign mem_raddr = (state == ST_IDLE) ? req_addr[MEM_AW-1:0] : a_q;
  assign mem_we    = (state == ST_WR) || (state == ST_WALK);
  assign mem_waddr = (state == ST_WR) ? a_q : ptr;
  assign mem_wdata = (state == ST_WR) ? (mem_rdata | wd_q) : 8'h00;

  secflash_array #(.AW(MEM_AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  assign opt_wr_en = (state == ST_WR) && optw_q;
  assign opt_clr   = take && accept &&
                     ((op == OP_MERASE) || ((op == OP_PERASE) && last_page));

  secflash_optreg u_optreg (
    .clk(clk), .rst(rst), .wr_en(opt_wr_en), .wdata(wd_q), .clr(opt_clr),
    .opt_byte(opt_byte), .lock(lock), .secure(secure),
    .boot_flash(boot_flash), .halt_dis(halt_dis)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      err    <= 1'b0;
      rdata  <= 8'h00;
      rsel_q <= SEL_MEM;
      a_q    <= '0;
      ptr    <= '0;
      wd_q   <= 8'h00;
      optw_q <= 1'b0;
      mass_q <= 1'b0;
      cnt    <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          if (!accept) begin
            done  <= 1'b1;
            err   <= 1'b1;
            rdata <= 8'hFF;
          end else begin
            unique case (op)
              OP_READ: begin
                state  <= ST_RD;
                rsel_q <= rsel_d;
              end
              OP_WRITE: begin
                state  <= ST_WR;
                a_q    <= req_addr[MEM_AW-1:0];
                wd_q   <= req_wdata;
                optw_q <= opt_hit;
              end
              default: begin
                state  <= ST_WAIT;
                cnt    <= CNT_W'(ERASE_WAIT - 1);
                mass_q <= (op == OP_MERASE);
                ptr    <= (op == OP_MERASE) ? '0 :
                          {req_addr[MEM_AW-1:PAGE_AW], {PAGE_AW{1'b0}}};
              end
            endcase
          end
        end
        ST_RD: begin
          unique case (rsel_q)
            SEL_OPT:  rdata <= opt_byte;
            SEL_ONES: rdata <= 8'hFF;
            default:  rdata <= mem_rdata;
          endcase
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        ST_WR: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            state <= ST_WALK;
            cnt   <= mass_q ? CNT_W'(DEPTH - 1) : CNT_W'(PAGE_BYTES - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          ptr <= ptr + 1'b1;
          if (cnt == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R2
  no_program_secured_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_wdata != 8'h00) |-> !secure);
  // R4
  reject_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> $past(state == ST_IDLE));
  // R5
  mass_erase_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (take && op == OP_MERASE) |=> busy);
endmodule

// File: tb/secflash_ctrl_tb.sv
module secflash_ctrl_tb;
  localparam int W    = 16;
  localparam int PAGE = 128;
  localparam int DEP  = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        busy, done, err, boot_flash, halt_dis;
  logic [7:0]  rdata;

  always #5 clk = ~clk;

  secflash_ctrl #(.MEM_AW(11), .PAGE_BYTES(PAGE), .ERASE_WAIT(W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .boot_flash(boot_flash), .halt_dis(halt_dis)
  );

  typedef struct {
    logic       err;
    logic       chk_rd;
    logic [7:0] rd;
    string      tag;
  } item_t;

  item_t q[$];
  int mon_cmp = 0, mon_fail = 0, drv_cmp = 0, drv_fail = 0, wd_fail = 0;
  int busy_total = 0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             mon_cmp + drv_cmp + wd_fail, mon_fail + drv_fail + wd_fail);
    $finish;
  endtask

  // monitor: counts busy cycles and scores each completion
  always @(negedge clk) begin
    if (busy) busy_total++;
    if (done) begin
      if (q.size() == 0) begin
        mon_fail++;
        $display("FAIL R11 unexpected done: actual done=1 expected done=0");
      end else begin
        item_t it;
        it = q.pop_front();
        mon_cmp++;
        if (err !== it.err || (it.chk_rd && rdata !== it.rd)) begin
          mon_fail++;
          $display("FAIL %s: actual err=%0b rdata=%02h expected err=%0b rdata=%02h",
                   it.tag, err, rdata, it.err, it.rd);
        end
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [7:0] wd,
                       input logic e, input logic c, input logic [7:0] r, input string tag);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it.err = e; it.chk_rd = c; it.rd = r; it.tag = tag;
    q.push_back(it);
    req_op = op; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic erase(input logic [1:0] op, input logic [15:0] a, input logic e,
                       input int exp_busy, input string tag);
    int b0;
    b0 = busy_total;
    issue(op, a, 8'h00, e, 1'b0, 8'h00, tag);
    drv_cmp++;
    if (busy_total - b0 != exp_busy) begin
      drv_fail++;
      $display("FAIL %s busy length: actual %0d expected %0d", tag, busy_total - b0, exp_busy);
    end
  endtask

  task automatic chk_cfg(input logic bf, input logic hd, input string tag);
    drv_cmp++;
    if (boot_flash !== bf || halt_dis !== hd) begin
      drv_fail++;
      $display("FAIL %s cfg: actual boot=%0b halt=%0b expected boot=%0b halt=%0b",
               tag, boot_flash, halt_dis, bf, hd);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    do_reset();
    chk_cfg(1'b0, 1'b0, "R8 erased config after reset");
    drv_cmp++;
    if (busy !== 1'b0 || done !== 1'b0) begin
      drv_fail++;
      $display("FAIL R10 reset idle: actual busy=%0b done=%0b expected 0 0", busy, done);
    end
    issue(2'b00, 16'h0010, 8'h00, 1'b0, 1'b1, 8'h00, "R1 erased read");
    issue(2'b01, 16'h0010, 8'hA5, 1'b0, 1'b0, 8'h00, "R2 program");
    issue(2'b00, 16'h0010, 8'h00, 1'b0, 1'b1, 8'hA5, "R1 read back");
    issue(2'b01, 16'h0010, 8'h5A, 1'b0, 1'b0, 8'h00, "R2 second program");
    issue(2'b00, 16'h0010, 8'h00, 1'b0, 1'b1, 8'hFF, "R2 OR merge");
    issue(2'b00, 16'h0800, 8'h00, 1'b1, 1'b0, 8'h00, "R7 out of range read");
    issue(2'b01, 16'h0800, 8'h11, 1'b1, 1'b0, 8'h00, "R7 out of range write");
    issue(2'b01, 16'hFFFF, 8'h03, 1'b0, 1'b0, 8'h00, "R6 config program");
    issue(2'b01, 16'h07FF, 8'h04, 1'b1, 1'b0, 8'h00, "R6 config reprogram");
    issue(2'b00, 16'hFFFF, 8'h00, 1'b0, 1'b1, 8'h03, "R7 alias read");
    issue(2'b00, 16'h07FF, 8'h00, 1'b0, 1'b1, 8'h03, "R7 physical config read");
    chk_cfg(1'b0, 1'b0, "R8 no change before reset");
    do_reset();
    chk_cfg(1'b1, 1'b1, "R8 captured at reset");
    issue(2'b01, 16'hFFFF, 8'h00, 1'b1, 1'b0, 8'h00, "R6 lock kept over reset");
    erase(2'b10, 16'h0015, 1'b0, W + PAGE, "R4 R10 page erase");
    issue(2'b00, 16'h0010, 8'h00, 1'b0, 1'b1, 8'h00, "R4 page cleared");
    issue(2'b01, 16'h0020, 8'h3C, 1'b0, 1'b0, 8'h00, "R2 program low page");
    issue(2'b01, 16'h07A0, 8'h11, 1'b0, 1'b0, 8'h00, "R2 program last page");
    erase(2'b10, 16'h07C0, 1'b0, W + PAGE, "R4 last page erase");
    issue(2'b00, 16'h07A0, 8'h00, 1'b0, 1'b1, 8'h00, "R4 last page cleared");
    issue(2'b00, 16'h0020, 8'h00, 1'b0, 1'b1, 8'h3C, "R4 other page kept");
    issue(2'b00, 16'hFFFF, 8'h00, 1'b0, 1'b1, 8'h00, "R6 config cleared");
    chk_cfg(1'b1, 1'b1, "R8 stable after config erase");
    issue(2'b01, 16'hFFFF, 8'h07, 1'b0, 1'b0, 8'h00, "R6 R9 program secured config");
    issue(2'b00, 16'h0020, 8'h00, 1'b0, 1'b1, 8'hFF, "R3 secured read");
    issue(2'b00, 16'h07FF, 8'h00, 1'b0, 1'b1, 8'h07, "R3 secured config read");
    issue(2'b00, 16'hFFFF, 8'h00, 1'b0, 1'b1, 8'h07, "R7 secured alias read");
    issue(2'b01, 16'h0030, 8'h12, 1'b1, 1'b0, 8'h00, "R2 R9 secured program");
    erase(2'b10, 16'h0000, 1'b1, 0, "R4 secured page erase");
    issue(2'b00, 16'h0020, 8'h00, 1'b0, 1'b1, 8'hFF, "R3 still hidden");
    // R5 R11: whole-array erase while secured, with a program attempt during busy
    begin
      item_t it;
      int b0;
      @(negedge clk);
      b0 = busy_total;
      it.err = 1'b0; it.chk_rd = 1'b0; it.rd = 8'h00; it.tag = "R5 mass erase";
      q.push_back(it);
      req_op = 2'b11; req_addr = 16'h0000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      req_op = 2'b01; req_addr = 16'h0040; req_wdata = 8'h77; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (q.size() != 0) @(posedge clk);
      repeat (3) @(negedge clk);
      drv_cmp++;
      if (busy_total - b0 != W + DEP) begin
        drv_fail++;
        $display("FAIL R10 mass busy: actual %0d expected %0d", busy_total - b0, W + DEP);
      end
    end
    issue(2'b00, 16'h0020, 8'h00, 1'b0, 1'b1, 8'h00, "R5 array cleared");
    issue(2'b00, 16'hFFFF, 8'h00, 1'b0, 1'b1, 8'h00, "R5 config cleared");
    issue(2'b00, 16'h0040, 8'h00, 1'b0, 1'b1, 8'h00, "R11 ignored program");
    issue(2'b01, 16'h0030, 8'h12, 1'b0, 1'b0, 8'h00, "R9 unsecured program");
    issue(2'b00, 16'h0030, 8'h00, 1'b0, 1'b1, 8'h12, "R9 unsecured read");
    do_reset();
    chk_cfg(1'b0, 1'b0, "R8 erased config recaptured");
    summary();
  end
endmodule